// File: doc/BRIEF.md
# Peripheral Clock Disable with Register Freeze

This block sits between a chip's register bus and six on-chip peripherals: a USB function, an ADC, two general timers and two serial controllers. A small control word holds one disable bit for each of them. A set bit stops that peripheral's clock. It also makes the peripheral's registers read-only, so every read returns the contents they held when the bit was set. Clearing the bit brings back the clock and write access, and the contents are left as they were.

Each peripheral's register file is stood in for by a small generic array clocked from its own gated clock. The enable of each gated clock passes through a latch that is transparent while the clock is low, so the gated clock can never be cut short or glitch. Register accesses arrive on one valid/ready request channel, with a select field that names the peripheral. Read data returns on a valid/ready response channel. Writes produce no response.

Back-pressure works like this. `req_ready` is high whenever the single response slot is empty, or is being drained in the same cycle (`rsp_ready` high). A read accepted at a clock edge presents its data on `rsp_valid`/`rsp_data` after that edge. The data is held unchanged until a cycle in which `rsp_ready` is high.

Top module: `periph_gate_top`

## Requirements
- R1: After reset the control word reads all zeros, every gated clock toggles with the main clock, and every register of every peripheral reads zero.
- R2: A control write (`ctl_wr_en` high at an edge) makes `ctl_rdata` equal the written word after that edge. Bit 0 is USB, bit 1 ADC, bit 2 timer 1, bit 3 timer 2, bit 4 serial controller 1, bit 5 serial controller 2. The same numbers are the peripheral select values on `req_periph`.
- R3: From the first edge after a disable bit is written as 1, the matching `pclk_out` bit shows no rising edge. The other gated clocks keep toggling.
- R4: A write request to a disabled peripheral leaves all of its registers unchanged.
- R5: A read of a disabled peripheral returns the value the register held at the moment the peripheral was disabled.
- R6: When a disable bit is cleared, the clock resumes and writes are accepted again from the next cycle on, and the register contents are unchanged by the disabled period.
- R7: A write to an enabled peripheral is returned by a later read of the same register and changes no register of any other peripheral.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_valid` and `rsp_data` hold steady on the next cycle.
- R9: A select value of 6 or 7 (no peripheral) makes a write do nothing and a read return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Write strobe for the disable word |
| ctl_wdata | input | NUM_PERIPH | New disable word |
| ctl_rdata | output | NUM_PERIPH | Current disable word |
| req_valid | input | 1 | Register access request valid |
| req_ready | output | 1 | Request may be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_periph | input | SEL_W | Peripheral select |
| req_addr | input | ADDR_W | Register index inside the peripheral |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer accepts read data |
| rsp_data | output | DATA_W | Read data |
| pclk_out | output | NUM_PERIPH | Gated clock of each peripheral |

## Verification
The bench builds the block with its defaults: six peripherals, four 16-bit registers each, and therefore a 3-bit select. The 3-bit select leaves the codes 6 and 7 free, so the no-peripheral path can be reached. Four registers per peripheral keep a full sweep of every register in every peripheral short. That sweep lets the bench detect a freeze or write block that leaks into a neighbouring peripheral or register. Counting rising edges on each gated clock makes the stopped-clock behaviour visible at the ports, separately from the register blocking.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
  // peripheral select codes; also the bit positions of the disable word
  typedef enum logic [2:0] {
    PID_USB  = 3'd0,
    PID_ADC  = 3'd1,
    PID_TMR1 = 3'd2,
    PID_TMR2 = 3'd3,
    PID_SER1 = 3'd4,
    PID_SER2 = 3'd5
  } periph_id_e;

  localparam int DEF_NUM_PERIPH = 6;
  localparam int DEF_NUM_REGS   = 4;
  localparam int DEF_DATA_W     = 16;
endpackage

// File: rtl/pgate_ctl_reg.sv
module pgate_ctl_reg #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] dis
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dis <= '0;
    else if (wr_en) dis <= wdata;
  end
endmodule

// File: rtl/pgate_clk_gate.sv
module pgate_clk_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_l;

  // enable only changes while clk is low, so the high phase is never cut
  always_latch begin
    if (!clk) en_l = en;
  end

  assign gclk = clk & en_l;
endmodule

// File: rtl/pgate_regfile.sv
module pgate_regfile #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic              pclk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr] <= wr_data;
    end
  end

  assign rd_data = mem[addr];
endmodule

// File: rtl/pgate_router.sv
module pgate_router #(
  parameter int N      = 6,
  parameter int SW     = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [SW-1:0]     req_periph,
  input  logic [N-1:0]      dis,
  input  logic [DATA_W-1:0] rd_data [N],
  output logic [N-1:0]      wr_en,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  logic              accept;
  logic [DATA_W-1:0] sel_data;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  // a disabled peripheral never sees a write strobe
  for (genvar g = 0; g < N; g++) begin : g_wr
    assign wr_en[g] = accept && req_write && !dis[g] && (req_periph == SW'(g));
  end

  // unmatched select codes read as zero
  always_comb begin
    sel_data = '0;
    for (int i = 0; i < N; i++) begin
      if (req_periph == SW'(i)) sel_data = rd_data[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= sel_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/periph_gate_top.sv
module periph_gate_top
  import pgate_pkg::*;
#(
  parameter int NUM_PERIPH = DEF_NUM_PERIPH,
  parameter int NUM_REGS   = DEF_NUM_REGS,
  parameter int DATA_W     = DEF_DATA_W,
  localparam int SEL_W     = $clog2(NUM_PERIPH),
  localparam int ADDR_W    = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_wr_en,
  input  logic [NUM_PERIPH-1:0] ctl_wdata,
  output logic [NUM_PERIPH-1:0] ctl_rdata,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [SEL_W-1:0]      req_periph,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_data,
  output logic [NUM_PERIPH-1:0] pclk_out
);
  logic [NUM_PERIPH-1:0] dis;
  logic [NUM_PERIPH-1:0] wr_en;
  logic [DATA_W-1:0]     rd_data [NUM_PERIPH];

  pgate_ctl_reg #(.N(NUM_PERIPH)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ctl_wr_en),
    .wdata (ctl_wdata),
    .dis   (dis)
  );

  assign ctl_rdata = dis;

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_per
    pgate_clk_gate u_cg (
      .clk  (clk),
      .en   (!dis[g]),
      .gclk (pclk_out[g])
    );

    pgate_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rf (
      .pclk    (pclk_out[g]),
      .rst_n   (rst_n),
      .wr_en   (wr_en[g]),
      .addr    (req_addr),
      .wr_data (req_wdata),
      .rd_data (rd_data[g])
    );
  end

  pgate_router #(.N(NUM_PERIPH), .SW(SEL_W), .DATA_W(DATA_W)) u_rt (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_periph (req_periph),
    .dis        (dis),
    .rd_data    (rd_data),
    .wr_en      (wr_en),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_data   (rsp_data)
  );
endmodule

// File: rtl/pgate_chk.sv
module pgate_chk #(
  parameter int N  = 6,
  parameter int SW = 3,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr_en,
  input logic [N-1:0]  ctl_wdata,
  input logic [N-1:0]  ctl_rdata,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [SW-1:0] req_periph,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data
);
  // R1
  ctl_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ctl_rdata == '0);

  // R2
  ctl_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en |=> ctl_rdata == $past(ctl_wdata));

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R8
  req_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R9
  range_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && (int'(req_periph) >= N)
    |=> rsp_valid && rsp_data == '0);
endmodule

bind periph_gate_top pgate_chk #(.N(NUM_PERIPH), .SW(SEL_W), .DW(DATA_W)) u_chk (.*);

// File: tb/sim_periph_gate_top.sv
module sim_periph_gate_top;
  localparam int NP = 6;
  localparam int NR = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_wr_en = 1'b0;
  logic [NP-1:0] ctl_wdata = '0;
  logic [NP-1:0] ctl_rdata;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [2:0]    req_periph = '0;
  logic [1:0]    req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic [NP-1:0] pclk_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [DW-1:0] mdl [8][NR];
  logic [NP-1:0] dis_m = '0;
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  int            ecnt [NP];
  int            snap [NP];

  always #4 clk = ~clk;

  periph_gate_top u0 (.*);

  for (genvar g = 0; g < NP; g++) begin : g_cnt
    initial ecnt[g] = 0;
    always @(posedge pclk_out[g]) ecnt[g] <= ecnt[g] + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R8 unexpected response", int'(rsp_data), 0);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_data == e, t, int'(rsp_data), int'(e));
      end
    end
  end

  task automatic send(input bit w, input int p, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = w;
    req_periph = 3'(p);
    req_addr   = 2'(a);
    req_wdata  = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic bus_write(input int p, input int a, input logic [DW-1:0] d);
    if (p < NP && !dis_m[p]) mdl[p][a] = d;
    send(1'b1, p, a, d);
  endtask

  task automatic bus_read(input int p, input int a, input string tag);
    exp_q.push_back((p < NP) ? mdl[p][a] : '0);
    tag_q.push_back(tag);
    send(1'b0, p, a, '0);
  endtask

  task automatic ctl_write(input logic [NP-1:0] v);
    @(negedge clk);
    ctl_wr_en = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_wr_en = 1'b0;
    dis_m = v;
    check(ctl_rdata == v, "R2 control word", int'(ctl_rdata), int'(v));
  endtask

  task automatic clk_window(input string tag);
    for (int i = 0; i < NP; i++) snap[i] = ecnt[i];
    repeat (5) @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      int want;
      want = dis_m[i] ? 0 : 5;
      check(ecnt[i] - snap[i] == want, tag, ecnt[i] - snap[i], want);
    end
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(exp_q.size() == 0, "R8 responses drained", exp_q.size(), 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 8; p++)
      for (int a = 0; a < NR; a++) mdl[p][a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ctl_rdata == '0, "R1 control reset", int'(ctl_rdata), 0);
    check(!rsp_valid, "R1 no response after reset", int'(rsp_valid), 0);
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < NR; a++) bus_read(p, a, "R1 register reset");
    clk_window("R1 clocks running");

    // R7 write every register, read back
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < NR; a++) bus_write(p, a, 16'(16'h1005 * (p + 1) + a * 16'h0111));
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < NR; a++) bus_read(p, a, "R7 write readback");
    drain();

    // R3/R4/R5 disable timer 1 (bit 2)
    ctl_write(6'b000100);
    clk_window("R3 gated clock stops");
    bus_write(2, 1, 16'hDEAD);
    bus_write(2, 3, 16'hBEEF);
    for (int a = 0; a < NR; a++) bus_read(2, a, "R4 R5 frozen timer1");
    bus_write(3, 1, 16'h3A3A);
    bus_read(3, 1, "R7 neighbour still writable");
    drain();

    // R6 re-enable timer 1, disable USB, timer 2, serial 2
    ctl_write(6'b101001);
    clk_window("R3 R6 clock pattern after change");
    bus_read(2, 1, "R6 contents unchanged");
    bus_write(2, 1, 16'h2222);
    bus_read(2, 1, "R6 write accepted again");
    for (int p = 0; p < NP; p++) begin
      if (dis_m[p]) begin
        bus_write(p, 0, 16'h7777);
        bus_read(p, 0, "R4 R5 write ignored while disabled");
      end
    end
    drain();

    // R9 out of range selects
    bus_write(6, 0, 16'h5555);
    bus_write(7, 2, 16'h6666);
    bus_read(6, 0, "R9 select 6 reads zero");
    bus_read(7, 2, "R9 select 7 reads zero");
    bus_read(1, 0, "R9 no side effect on ADC");
    drain();

    // R8 back-pressure
    @(posedge clk);
    #1 rsp_ready = 1'b0;
    bus_read(4, 2, "R8 held response");
    @(negedge clk);
    check(rsp_valid, "R8 response held valid", int'(rsp_valid), 1);
    check(!req_ready, "R8 request stalled", int'(req_ready), 0);
    check(rsp_data == mdl[4][2], "R8 held data", int'(rsp_data), int'(mdl[4][2]));
    @(posedge clk);
    #1 rsp_ready = 1'b1;
    drain();

    // R6 full re-enable
    ctl_write('0);
    clk_window("R6 all clocks back");
    for (int p = 0; p < NP; p++) begin
      bus_write(p, 3, 16'(16'hA000 + p));
      bus_read(p, 3, "R6 write after full enable");
    end
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule